// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the host-side register front end of a PS/2-style keyboard controller. The host reaches it through two byte-wide ports, selected by `wr_is_cmd`: a command port and a data port. A byte written to the command port is decoded as a controller command. Some commands answer at once with a reply byte. Some change the mode or output-port register. Others arm a pending operand slot, so that the next data-port byte is sent to a chosen target instead of to the keyboard.

Reply bytes leave on a one-cycle strobe toward the keyboard-side response path. The path is tagged as keyboard or auxiliary. Data bytes meant for the attached devices leave on a separate forwarding strobe. The block drives the A20 gate from output-port bit 1. It raises a one-cycle system reset request when software pulses or clears output-port bit 0. An unrecognised command byte produces a one-cycle error strobe and changes nothing.

Every effect is registered. A write accepted on one clock edge shows its strobe during the following cycle, and its register update is visible from that same edge.

Top module: `kbc_host_decoder`

## Requirements
- R1: After reset the mode register reads 0x03, status reads 0x18 (bit 3 last-write-was-command, bit 4 unlocked), the output port reads 0xCF, `a20_o` is 1, and all strobes are low.
- R2: Command 0x20 replies with the current mode byte, and command 0xD0 replies with the current output-port byte. A reply sets `rsp_valid` for one cycle with `rsp_aux`=0. Whenever a strobe is low, its data field is 0x00.
- R3: Command 0xAA replies 0x55 and sets status bit 2. Commands 0xA9 and 0xAB reply 0x00, and 0xC0 replies 0x80.
- R4: Command 0x60 arms the pending slot. The next data-port byte then replaces the mode register. `kbd_irq_en` equals mode bit 0 AND NOT mode bit 4, and `aux_irq_en` equals mode bit 1.
- R5: With nothing pending, a data-port byte is forwarded with `dev_valid`=1 and `dev_mouse`=0. After command 0xD4, the next data byte is forwarded with `dev_mouse`=1.
- R6: After command 0xD2 the next data byte is returned as a reply with `rsp_aux`=0. After 0xD3 it is returned with `rsp_aux`=1.
- R7: Any data-port write clears the pending slot, so a second data byte goes to the keyboard. A single write produces at most one of reply, forward, error and reset strobes.
- R8: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, which takes effect on `kbd_irq_en` at once.
- R9: Command 0xDF sets output-port bit 1 and drives `a20_o` high. Command 0xDD clears both.
- R10: After command 0xD1, the next data byte replaces the output port and `a20_o` follows its bit 1. A reset request pulses if its bit 0 is 0.
- R11: A command byte whose upper four bits are all 1 pulses `sys_rst_req` for one cycle when bit 0 is 0. When bit 0 is 1 it does nothing.
- R12: Any other command byte raises `cmd_err` for one cycle and leaves mode, status, output port and pending slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_is_cmd | input | 1 | 1 selects command port, 0 data port |
| wr_data | input | 8 | Written byte |
| mode_o | output | 8 | Mode register |
| status_o | output | 8 | Status register |
| outport_o | output | 8 | Output-port register |
| a20_o | output | 1 | A20 gate level |
| kbd_irq_en | output | 1 | Keyboard interrupt enable from mode |
| aux_irq_en | output | 1 | Auxiliary interrupt enable from mode |
| rsp_valid | output | 1 | Reply byte strobe |
| rsp_aux | output | 1 | Reply tagged as auxiliary |
| rsp_data | output | 8 | Reply byte |
| dev_valid | output | 1 | Device forward strobe |
| dev_mouse | output | 1 | Forward targets mouse (else keyboard) |
| dev_data | output | 8 | Forwarded byte |
| cmd_err | output | 1 | Unknown command strobe |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is the interaction between the pending slot and the command that armed it. The right effect depends on the earlier command and shows up only on the following data write. The stimulus sweeps all 256 command bytes, each from a fresh reset. Every command is followed by the same probe data byte, 0xA5, and the probe's destination is checked against what that command should have armed. The same sweep covers the folded 0xF0–0xFF range and every unknown code. Directed sequences then cover a reset pulse caused by a cleared output-port bit 0, and read-back of registers modified earlier.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] MODE_RST = 8'h03;
  localparam logic [BYTE_W-1:0] STAT_RST = 8'h18;
  localparam logic [BYTE_W-1:0] OUTP_RST = 8'hCF;
  localparam int STAT_SELFTEST_BIT = 2;
  localparam int OUTP_A20_BIT      = 1;
  localparam int OUTP_RUN_BIT      = 0;

  typedef enum logic [2:0] {
    PW_NONE, PW_MODE, PW_OUTP, PW_OBUF, PW_AUXB, PW_MOUSE
  } pend_e;

  typedef enum logic [3:0] {
    OP_NOP, OP_BAD, OP_RD_MODE, OP_RD_OUTP, OP_REPLY, OP_SELFTEST,
    OP_ARM, OP_SETMODE, OP_CLRMODE, OP_A20_ON, OP_A20_OFF, OP_PULSE
  } op_e;

  typedef struct packed {
    op_e               op;
    pend_e             arm;
    logic [BYTE_W-1:0] arg;
  } dec_t;
endpackage

// File: rtl/kbc_cmd_classify.sv
module kbc_cmd_classify
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output dec_t              dec
);
  always_comb begin
    dec.op  = OP_BAD;
    dec.arm = PW_NONE;
    dec.arg = '0;
    if (&cmd[BYTE_W-1:BYTE_W-4]) begin
      dec.op = cmd[0] ? OP_NOP : OP_PULSE;
    end else begin
      unique case (cmd)
        8'h20: dec.op = OP_RD_MODE;
        8'hD0: dec.op = OP_RD_OUTP;
        8'h60: begin dec.op = OP_ARM; dec.arm = PW_MODE;  end
        8'hD1: begin dec.op = OP_ARM; dec.arm = PW_OUTP;  end
        8'hD2: begin dec.op = OP_ARM; dec.arm = PW_OBUF;  end
        8'hD3: begin dec.op = OP_ARM; dec.arm = PW_AUXB;  end
        8'hD4: begin dec.op = OP_ARM; dec.arm = PW_MOUSE; end
        8'hA7: begin dec.op = OP_SETMODE; dec.arg = 8'h20; end
        8'hA8: begin dec.op = OP_CLRMODE; dec.arg = 8'h20; end
        8'hAD: begin dec.op = OP_SETMODE; dec.arg = 8'h10; end
        8'hAE: begin dec.op = OP_CLRMODE; dec.arg = 8'h10; end
        8'hAA: begin dec.op = OP_SELFTEST; dec.arg = 8'h55; end
        8'hA9, 8'hAB: begin dec.op = OP_REPLY; dec.arg = 8'h00; end
        8'hC0: begin dec.op = OP_REPLY; dec.arg = 8'h80; end
        8'hDF: dec.op = OP_A20_ON;
        8'hDD: dec.op = OP_A20_OFF;
        default: dec.op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/kbc_reg_file.sv
module kbc_reg_file
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  dec_t              dec,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] status_q,
  output logic [BYTE_W-1:0] outp_q,
  output pend_e             pend_q
);
  logic [BYTE_W-1:0] mode_d, status_d, outp_d;
  pend_e             pend_d;

  always_comb begin
    mode_d   = mode_q;
    status_d = status_q;
    outp_d   = outp_q;
    pend_d   = pend_q;
    if (wr_is_cmd) begin
      unique case (dec.op)
        OP_SETMODE:  mode_d = mode_q | dec.arg;
        OP_CLRMODE:  mode_d = mode_q & ~dec.arg;
        OP_SELFTEST: status_d[STAT_SELFTEST_BIT] = 1'b1;
        OP_A20_ON:   outp_d[OUTP_A20_BIT] = 1'b1;
        OP_A20_OFF:  outp_d[OUTP_A20_BIT] = 1'b0;
        OP_ARM:      pend_d = dec.arm;
        default: ;
      endcase
    end else begin
      pend_d = PW_NONE;
      if (pend_q == PW_MODE) mode_d = wr_data;
      if (pend_q == PW_OUTP) outp_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      status_q <= STAT_RST;
      outp_q   <= OUTP_RST;
      pend_q   <= PW_NONE;
    end else if (wr_en) begin
      mode_q   <= mode_d;
      status_q <= status_d;
      outp_q   <= outp_d;
      pend_q   <= pend_d;
    end
  end

  assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(mode_q));
  assert_outp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(outp_q));
endmodule

// File: rtl/kbc_host_decoder.sv
module kbc_host_decoder
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] outport_o,
  output logic              a20_o,
  output logic              kbd_irq_en,
  output logic              aux_irq_en,
  output logic              rsp_valid,
  output logic              rsp_aux,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              dev_valid,
  output logic              dev_mouse,
  output logic [BYTE_W-1:0] dev_data,
  output logic              cmd_err,
  output logic              sys_rst_req
);
  dec_t              dec;
  pend_e             pend_q;
  logic              rsp_v_d, rsp_a_d, dev_v_d, dev_m_d, err_d, rst_d;
  logic [BYTE_W-1:0] rsp_dat_d, dev_dat_d;

  kbc_cmd_classify u_classify (.cmd(wr_data), .dec(dec));

  kbc_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_cmd(wr_is_cmd),
    .wr_data(wr_data), .dec(dec), .mode_q(mode_o), .status_q(status_o),
    .outp_q(outport_o), .pend_q(pend_q)
  );

  assign a20_o      = outport_o[OUTP_A20_BIT];
  assign kbd_irq_en = mode_o[0] & ~mode_o[4];
  assign aux_irq_en = mode_o[1];

  always_comb begin
    rsp_v_d = 1'b0; rsp_a_d = 1'b0; rsp_dat_d = '0;
    dev_v_d = 1'b0; dev_m_d = 1'b0; dev_dat_d = '0;
    err_d   = 1'b0; rst_d   = 1'b0;
    if (wr_en) begin
      if (wr_is_cmd) begin
        unique case (dec.op)
          OP_RD_MODE: begin rsp_v_d = 1'b1; rsp_dat_d = mode_o;    end
          OP_RD_OUTP: begin rsp_v_d = 1'b1; rsp_dat_d = outport_o; end
          OP_REPLY, OP_SELFTEST: begin rsp_v_d = 1'b1; rsp_dat_d = dec.arg; end
          OP_PULSE:   rst_d = 1'b1;
          OP_BAD:     err_d = 1'b1;
          default: ;
        endcase
      end else begin
        unique case (pend_q)
          PW_NONE:  begin dev_v_d = 1'b1; dev_dat_d = wr_data; end
          PW_MOUSE: begin dev_v_d = 1'b1; dev_m_d = 1'b1; dev_dat_d = wr_data; end
          PW_OBUF:  begin rsp_v_d = 1'b1; rsp_dat_d = wr_data; end
          PW_AUXB:  begin rsp_v_d = 1'b1; rsp_a_d = 1'b1; rsp_dat_d = wr_data; end
          PW_OUTP:  rst_d = ~wr_data[OUTP_RUN_BIT];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_aux <= 1'b0; rsp_data <= '0;
      dev_valid <= 1'b0; dev_mouse <= 1'b0; dev_data <= '0;
      cmd_err   <= 1'b0; sys_rst_req <= 1'b0;
    end else begin
      rsp_valid <= rsp_v_d; rsp_aux <= rsp_a_d; rsp_data <= rsp_dat_d;
      dev_valid <= dev_v_d; dev_mouse <= dev_m_d; dev_data <= dev_dat_d;
      cmd_err   <= err_d;   sys_rst_req <= rst_d;
    end
  end

  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, dev_valid, cmd_err, sys_rst_req}));
  assert_err_from_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(wr_en && wr_is_cmd));
  assert_rst_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_en));
  assert_fwd_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> $past(wr_en && !wr_is_cmd));
endmodule

// File: tb/kbc_host_decoder_test.sv
module kbc_host_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_is_cmd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] mode_o, status_o, outport_o, rsp_data, dev_data;
  logic a20_o, kbd_irq_en, aux_irq_en, rsp_valid, rsp_aux, dev_valid, dev_mouse;
  logic cmd_err, sys_rst_req;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  kbc_host_decoder uut (.*);

  // event vector: rsp_valid, rsp_aux, rsp_data, dev_valid, dev_mouse, dev_data, cmd_err, sys_rst_req
  function automatic logic [21:0] ev(logic rv, logic ra, logic [7:0] rd,
      logic dv, logic dm, logic [7:0] dd, logic er, logic rs);
    return {rv, ra, rd, dv, dm, dd, er, rs};
  endfunction

  function automatic logic [21:0] act_ev();
    return {rsp_valid, rsp_aux, rsp_data, dev_valid, dev_mouse, dev_data, cmd_err, sys_rst_req};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // one write; returns at the negedge where its strobes are visible
  task automatic wr(logic is_cmd, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_is_cmd = is_cmd; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic bit known(logic [7:0] c);
    if (c[7:4] == 4'hF) return 1;
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE, 8'hC0,
      8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [21:0] cmd_exp(logic [7:0] c);
    if (c[7:4] == 4'hF) return ev(0,0,0,0,0,0,0,!c[0]);
    case (c)
      8'h20: return ev(1,0,8'h03,0,0,0,0,0);
      8'hD0: return ev(1,0,8'hCF,0,0,0,0,0);
      8'hAA: return ev(1,0,8'h55,0,0,0,0,0);
      8'hA9, 8'hAB: return ev(1,0,8'h00,0,0,0,0,0);
      8'hC0: return ev(1,0,8'h80,0,0,0,0,0);
      default: return ev(0,0,0,0,0,0,!known(c),0);
    endcase
  endfunction

  initial begin
    fork
      begin
        do_reset();
        // R1 reset state
        chk("R1 mode", mode_o, 8'h03);
        chk("R1 status", status_o, 8'h18);
        chk("R1 outport", outport_o, 8'hCF);
        chk("R1 a20/irq", {a20_o, kbd_irq_en, aux_irq_en}, 3'b111);
        chk("R1 strobes", act_ev(), 22'h0);

        // sweep: every command byte, then probe data 0xA5
        for (int c = 0; c < 256; c++) begin
          logic [7:0] cb, em, eo, es;
          cb = c[7:0];
          do_reset();
          wr(1'b1, cb);
          chk($sformatf("R2/R3/R11/R12 cmd %h events", cb), act_ev(), cmd_exp(cb));
          em = (cb == 8'hA7) ? 8'h23 : (cb == 8'hAD) ? 8'h13 : 8'h03;
          eo = (cb == 8'hDD) ? 8'hCD : 8'hCF;
          es = (cb == 8'hAA) ? 8'h1C : 8'h18;
          chk($sformatf("R8/R9/R3/R12 cmd %h regs", cb), {mode_o, outport_o, status_o}, {em, eo, es});
          @(negedge clk);
          chk($sformatf("R11 cmd %h one-cycle", cb), act_ev(), 22'h0);
          wr(1'b0, 8'hA5);
          case (cb)
            8'h60: begin
              chk("R4 probe none", act_ev(), 22'h0);
              chk("R4 mode loaded", {mode_o, kbd_irq_en, aux_irq_en}, {8'hA5, 1'b1, 1'b0});
            end
            8'hD1: begin
              chk("R10 probe none", act_ev(), 22'h0);
              chk("R10 outport loaded", {outport_o, a20_o}, {8'hA5, 1'b0});
            end
            8'hD2: chk("R6 kbd obuf", act_ev(), ev(1,0,8'hA5,0,0,0,0,0));
            8'hD3: chk("R6 aux obuf", act_ev(), ev(1,1,8'hA5,0,0,0,0,0));
            8'hD4: chk("R5 mouse fwd", act_ev(), ev(0,0,0,1,1,8'hA5,0,0));
            default: chk($sformatf("R5/R12 cmd %h probe kbd", cb), act_ev(), ev(0,0,0,1,0,8'hA5,0,0));
          endcase
        end

        // R7 pending cleared after one data byte
        do_reset();
        wr(1'b1, 8'hD4); wr(1'b0, 8'h11); wr(1'b0, 8'h22);
        chk("R7 second byte to kbd", act_ev(), ev(0,0,0,1,0,8'h22,0,0));

        // R10 output port bit0 clear -> reset pulse, one cycle
        do_reset();
        wr(1'b1, 8'hD1); wr(1'b0, 8'hCC);
        chk("R10 reset pulse", act_ev(), ev(0,0,0,0,0,0,0,1));
        chk("R10 a20 low", {outport_o, a20_o}, {8'hCC, 1'b0});
        @(negedge clk);
        chk("R10 pulse ends", sys_rst_req, 1'b0);
        wr(1'b1, 8'hD0);
        chk("R2 read outport", act_ev(), ev(1,0,8'hCC,0,0,0,0,0));

        // R9 A20 off/on with readback
        do_reset();
        wr(1'b1, 8'hDD); wr(1'b1, 8'hD0);
        chk("R9 a20 off read", {act_ev(), a20_o}, {ev(1,0,8'hCD,0,0,0,0,0), 1'b0});
        wr(1'b1, 8'hDF); wr(1'b1, 8'hD0);
        chk("R9 a20 on read", {act_ev(), a20_o}, {ev(1,0,8'hCF,0,0,0,0,0), 1'b1});

        // R8 disable/enable pairs and R4 readback via 0x20
        do_reset();
        wr(1'b1, 8'hAD);
        chk("R8 kbd disable irq", kbd_irq_en, 1'b0);
        wr(1'b1, 8'hA7); wr(1'b1, 8'h20);
        chk("R8/R2 mode read", act_ev(), ev(1,0,8'h33,0,0,0,0,0));
        wr(1'b1, 8'hAE); wr(1'b1, 8'hA8);
        chk("R8 restored", {mode_o, kbd_irq_en}, {8'h03, 1'b1});
        wr(1'b1, 8'h60); wr(1'b1, 8'h42);
        chk("R12 unknown keeps pending", cmd_err, 1'b1);
        wr(1'b0, 8'h10);
        chk("R4 mode after err", {mode_o, kbd_irq_en, aux_irq_en}, {8'h10, 1'b0, 1'b0});

        // R11 no-op fold
        wr(1'b1, 8'hF1);
        chk("R11 no-op", act_ev(), 22'h0);
      end
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule